// File: doc/BRIEF.md
# T1 Transmit Frame Timing Generator

This block produces the bit, time-slot and multiframe timing for a 1.544 Mb/s T1 transmit path. It runs at one bit per clock. A bit counter walks the 193 positions of a frame: the framing bit at position 0, then 24 eight-bit channels. A frame counter walks the frames of a multiframe. The multiframe is 12 frames long in superframe (SF) format and 24 frames long in extended superframe (ESF) format. The format is chosen by a level input.

Both counters free-run by default. A rising edge on the frame-sync input declares the current clock to be the framing bit of a new frame. A rising edge on the multiframe-sync input declares the current clock to be the framing bit of frame 1. Downstream logic uses the decoded strobes to:
- mark channel starts,
- locate signaling frames,
- pace the data-link source,
- sample link bits at the right framing-bit times.

Top module: `t1_tx_timing`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), bit_pos is 0 and frame_idx is 0, where frame_idx is the frame number minus one.
- R2: With no sync edge, bit_pos counts 0,1,...,192 and then returns to 0. On that return, frame_idx advances by one.
- R3: frame_idx wraps from 23 to 0 when esf_mode=1 and from 11 to 0 when esf_mode=0. If it is at or past the last frame of the selected format when it advances, it goes to 0.
- R4: chan_clk is high exactly when bit_pos is 1, 9, 17, ..., 185, which is the first bit of each channel. It is never high at bit 0.
- R5: mf_mark is high for the first half of the multiframe: frame_idx 0..11 in ESF and 0..5 in SF. It is low for the rest.
- R6: sig_frame is high exactly in frames whose number is a multiple of 6: frame_idx 5, 11, 17, 23 in ESF and 5, 11 in SF.
- R7: In ESF, sig_sel is high when frame_idx mod 12 < 6. This makes it high in frames 6 and 18 and low in frames 12 and 24. In SF, sig_sel is high when frame_idx mod 6 < 3.
- R8: link_clk is high during odd-numbered frames (frame_idx even) in ESF and during even-numbered frames (frame_idx odd) in SF.
- R9: link_strobe is high exactly when bit_pos is 0 and link_clk is high.
- R10: A rising edge of fsync_in, with no msync_in edge in the same cycle, makes that cycle bit 0 of a frame, so bit_pos is 1 on the next cycle. If bit_pos was not 0, frame_idx advances as at a frame wrap. If bit_pos was already 0, the edge has no effect. A level held high has no further effect.
- R11: A rising edge of msync_in makes that cycle bit 0 of frame 1, so bit_pos is 1 and frame_idx is 0 on the next cycle. This takes priority over a simultaneous fsync_in edge.
- R12: With both sync inputs low, one full multiframe of clocks (4632 in ESF, 2316 in SF) brings the counters back to the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate transmit clock, one bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| esf_mode | input | 1 | 1 selects 24-frame ESF, 0 selects 12-frame SF |
| fsync_in | input | 1 | Frame alignment input, rising edge marks bit 0 |
| msync_in | input | 1 | Multiframe alignment input, rising edge marks bit 0 of frame 1 |
| bit_pos | output | $clog2(FRAME_BITS) (8) | Current bit position within the frame |
| frame_idx | output | $clog2(ESF_FRAMES) (5) | Current frame number minus one |
| chan_clk | output | 1 | Pulse on the first bit of each channel |
| mf_mark | output | 1 | High for the first half of the multiframe |
| sig_sel | output | 1 | Signaling-frame selector clock |
| sig_frame | output | 1 | High during signaling frames |
| link_clk | output | 1 | Data-link demand clock, one period per two frames |
| link_strobe | output | 1 | High on the framing bit when the link input is taken |

## Verification
The hardest cases to reach are the sync edges that land where the counters are already aligned. Also hard are edges on the last bit of a frame or the last frame of a multiframe, and a format switch while frame_idx is past the SF limit. Free-running stimulus almost never produces these.

Directed sequences therefore place frame-sync edges mid-frame and exactly on bit 0, and place simultaneous edges on both sync inputs. A long constrained-random phase then adds sparse sync pulses, held sync levels and occasional format flips. Every output is compared on every cycle against a bench model of the counters.

// File: rtl/t1_tx_pkg.sv
// Package: shared types for the T1 transmit timing generator.
// Assumes one clock per line bit; all decode is relative to the counters.
package t1_tx_pkg;
    // Index of each alignment input inside the edge-detector vector
    typedef enum int {
        SYNC_FRAME = 0,
        SYNC_MULTI = 1
    } t1_sync_idx_e;

    localparam int SYNC_COUNT = 2;
endpackage

// File: rtl/t1_sync_edge.sv
// Module: rising-edge detector for a vector of level inputs.
// Assumes inputs are already synchronous to clk; the edge is reported in
// the same cycle the input is first seen high.
module t1_sync_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_in,
    output logic [N-1:0] rise_out
);
    logic [N-1:0] level_q;

    for (genvar i = 0; i < N; i++) begin : g_edge
        // Remember the previous level of input i
        always_ff @(posedge clk) begin
            if (!rst_n) level_q[i] <= 1'b0;
            else        level_q[i] <= level_in[i];
        end

        // Edge is new-high versus last-sampled-low
        assign rise_out[i] = level_in[i] & ~level_q[i];
    end
endmodule

// File: rtl/t1_bit_counter.sv
// Module: bit position counter within one T1 frame.
// A multiframe or frame sync edge marks the current cycle as bit 0, so
// the counter loads 1. frame_adv tells the frame counter to move on.
module t1_bit_counter #(
    parameter int FRAME_BITS = 193,
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs_rise,
    input  logic          ms_rise,
    output logic [BW-1:0] bit_cnt,
    output logic          frame_adv
);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] ONE      = BW'(1);

    // Frame advance: a wrap, or a sync edge arriving away from bit 0
    always_comb begin
        if (ms_rise)      frame_adv = 1'b0;
        else if (fs_rise) frame_adv = (bit_cnt != '0);
        else              frame_adv = (bit_cnt == LAST_BIT);
    end

    // Count bits, reloading after the edge cycle taken as bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)                  bit_cnt <= '0;
        else if (ms_rise || fs_rise) bit_cnt <= ONE;
        else if (bit_cnt == LAST_BIT) bit_cnt <= '0;
        else                         bit_cnt <= bit_cnt + ONE;
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == LAST_BIT && !fs_rise && !ms_rise) |=> (bit_cnt == '0));

    // R10
    fsync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_rise && !ms_rise) |=> (bit_cnt == ONE));
endmodule

// File: rtl/t1_frame_counter.sv
// Module: frame-within-multiframe counter for SF (12) or ESF (24).
// Assumes esf selects the limit live. An index past the SF limit after a
// format change wraps to 0 on its next advance.
module t1_frame_counter #(
    parameter int SF_FRAMES  = 12,
    parameter int ESF_FRAMES = 24,
    localparam int FW = $clog2(ESF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          esf,
    input  logic          advance,
    input  logic          restart,
    output logic [FW-1:0] frm_cnt
);
    localparam logic [FW-1:0] SF_LAST  = FW'(SF_FRAMES - 1);
    localparam logic [FW-1:0] ESF_LAST = FW'(ESF_FRAMES - 1);

    logic [FW-1:0] last_frm;

    // Pick the final frame index of the active format
    assign last_frm = esf ? ESF_LAST : SF_LAST;

    // Step or restart the frame index
    always_ff @(posedge clk) begin
        if (!rst_n)               frm_cnt <= '0;
        else if (restart)         frm_cnt <= '0;
        else if (advance) begin
            if (frm_cnt >= last_frm) frm_cnt <= '0;
            else                     frm_cnt <= frm_cnt + FW'(1);
        end
    end

    // R3
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_cnt <= ESF_LAST);

    // R3
    sf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!esf && advance && !restart && frm_cnt == SF_LAST) |=> (frm_cnt == '0));
endmodule

// File: rtl/t1_strobe_decode.sv
// Module: combinational decode of channel, multiframe, signaling and
// data-link strobes from the bit and frame counters.
// Assumes counters are registered, so the outputs follow them glitch-free.
module t1_strobe_decode #(
    parameter int FRAME_BITS  = 193,
    parameter int SLOT_BITS   = 8,
    parameter int SF_FRAMES   = 12,
    parameter int ESF_FRAMES  = 24,
    parameter int SIG_SPACING = 6,
    localparam int BW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(ESF_FRAMES)
) (
    input  logic [BW-1:0] bit_cnt,
    input  logic [FW-1:0] frm_cnt,
    input  logic          esf,
    output logic          chan_clk,
    output logic          mf_mark,
    output logic          sig_sel,
    output logic          sig_frame,
    output logic          link_clk,
    output logic          link_strobe
);
    int b_i;
    int f_i;

    assign b_i = int'(bit_cnt);
    assign f_i = int'(frm_cnt);

    // First bit of each channel, skipping the framing bit
    assign chan_clk = (b_i != 0) && (((b_i - 1) % SLOT_BITS) == 0);

    // First half of the multiframe
    assign mf_mark = esf ? (f_i < ESF_FRAMES / 2) : (f_i < SF_FRAMES / 2);

    // Frames whose number is a multiple of the signaling spacing
    assign sig_frame = (((f_i + 1) % SIG_SPACING) == 0);

    // Selector: ESF splits A/C from B/D, SF runs at twice the rate
    assign sig_sel = esf ? ((f_i % (2 * SIG_SPACING)) < SIG_SPACING)
                         : ((f_i % SIG_SPACING) < (SIG_SPACING / 2));

    // Demand clock: odd frames in ESF, even frames in SF
    assign link_clk = esf ? ((f_i % 2) == 0) : ((f_i % 2) == 1);

    // Link sample point: framing bit of a demanded frame
    assign link_strobe = (b_i == 0) && link_clk;
endmodule

// File: rtl/t1_tx_timing.sv
// Module: T1 transmit frame timing generator (top).
// Assumes one clk per line bit and synchronous sync inputs. Multiframe
// sync has priority over frame sync. Counters free-run with no syncs.
module t1_tx_timing #(
    parameter int FRAME_BITS  = 193,
    parameter int SLOT_BITS   = 8,
    parameter int SF_FRAMES   = 12,
    parameter int ESF_FRAMES  = 24,
    parameter int SIG_SPACING = 6,
    localparam int BW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(ESF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          esf_mode,
    input  logic          fsync_in,
    input  logic          msync_in,
    output logic [BW-1:0] bit_pos,
    output logic [FW-1:0] frame_idx,
    output logic          chan_clk,
    output logic          mf_mark,
    output logic          sig_sel,
    output logic          sig_frame,
    output logic          link_clk,
    output logic          link_strobe
);
    import t1_tx_pkg::*;

    logic [SYNC_COUNT-1:0] sync_lvl;
    logic [SYNC_COUNT-1:0] sync_rise;
    logic                  fs_rise;
    logic                  ms_rise;
    logic                  frame_adv;

    // Gather the alignment inputs for edge detection
    always_comb begin
        sync_lvl             = '0;
        sync_lvl[SYNC_FRAME] = fsync_in;
        sync_lvl[SYNC_MULTI] = msync_in;
    end

    assign fs_rise = sync_rise[SYNC_FRAME];
    assign ms_rise = sync_rise[SYNC_MULTI];

    t1_sync_edge #(.N(SYNC_COUNT)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sync_lvl),
        .rise_out (sync_rise)
    );

    t1_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_rise   (fs_rise),
        .ms_rise   (ms_rise),
        .bit_cnt   (bit_pos),
        .frame_adv (frame_adv)
    );

    t1_frame_counter #(
        .SF_FRAMES  (SF_FRAMES),
        .ESF_FRAMES (ESF_FRAMES)
    ) u_frames (
        .clk     (clk),
        .rst_n   (rst_n),
        .esf     (esf_mode),
        .advance (frame_adv),
        .restart (ms_rise),
        .frm_cnt (frame_idx)
    );

    t1_strobe_decode #(
        .FRAME_BITS  (FRAME_BITS),
        .SLOT_BITS   (SLOT_BITS),
        .SF_FRAMES   (SF_FRAMES),
        .ESF_FRAMES  (ESF_FRAMES),
        .SIG_SPACING (SIG_SPACING)
    ) u_decode (
        .bit_cnt     (bit_pos),
        .frm_cnt     (frame_idx),
        .esf         (esf_mode),
        .chan_clk    (chan_clk),
        .mf_mark     (mf_mark),
        .sig_sel     (sig_sel),
        .sig_frame   (sig_frame),
        .link_clk    (link_clk),
        .link_strobe (link_strobe)
    );

    // R11
    msync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_rise |=> (bit_pos == BW'(1) && frame_idx == '0));

    // R4
    chan_not_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clk |-> (bit_pos != '0));

    // R9
    strobe_on_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_strobe |-> (bit_pos == '0 && link_clk));

    // R10
    aligned_fsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_rise && !ms_rise && bit_pos == '0) |=> $stable(frame_idx));
endmodule

// File: tb/t1_tx_timing_bench.sv
`timescale 1ns/1ps
module t1_tx_timing_bench;
    localparam int FBITS = 193;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       esf_mode = 1'b1;
    logic       fsync_in = 1'b0;
    logic       msync_in = 1'b0;
    logic [7:0] bit_pos;
    logic [4:0] frame_idx;
    logic       chan_clk, mf_mark, sig_sel, sig_frame, link_clk, link_strobe;

    int checks = 0;
    int failures = 0;
    int mb = 0;
    int mf = 0;
    bit fprev = 1'b0;
    bit mprev = 1'b0;
    int seed_dummy;

    always #2 clk = ~clk;

    t1_tx_timing u_t1_tx_timing (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode),
        .fsync_in(fsync_in), .msync_in(msync_in),
        .bit_pos(bit_pos), .frame_idx(frame_idx),
        .chan_clk(chan_clk), .mf_mark(mf_mark), .sig_sel(sig_sel),
        .sig_frame(sig_frame), .link_clk(link_clk), .link_strobe(link_strobe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int last_frame(input bit esf);
        return esf ? 23 : 11;
    endfunction

    function automatic int e_chan(input int b);
        return (b > 0 && ((b - 1) % 8) == 0) ? 1 : 0;
    endfunction

    function automatic int e_mf(input int f, input bit esf);
        return (f < (esf ? 12 : 6)) ? 1 : 0;
    endfunction

    function automatic int e_sigfr(input int f);
        return (f == 5 || f == 11 || f == 17 || f == 23) ? 1 : 0;
    endfunction

    function automatic int e_sigsel(input int f, input bit esf);
        if (esf) return ((f % 12) < 6) ? 1 : 0;
        return ((f % 6) < 3) ? 1 : 0;
    endfunction

    function automatic int e_link(input int f, input bit esf);
        if (esf) return (f % 2 == 0) ? 1 : 0;
        return (f % 2 == 1) ? 1 : 0;
    endfunction

    // Compare every output with the model state
    task automatic check_all();
        chk("R2 bit_pos", int'(bit_pos), mb);
        chk("R3 frame_idx", int'(frame_idx), mf);
        chk("R4 chan_clk", int'(chan_clk), e_chan(mb));
        chk("R5 mf_mark", int'(mf_mark), e_mf(mf, esf_mode));
        chk("R6 sig_frame", int'(sig_frame), e_sigfr(mf));
        chk("R7 sig_sel", int'(sig_sel), e_sigsel(mf, esf_mode));
        chk("R8 link_clk", int'(link_clk), e_link(mf, esf_mode));
        chk("R9 link_strobe", int'(link_strobe),
            (mb == 0 && e_link(mf, esf_mode) == 1) ? 1 : 0);
    endtask

    // Drive one cycle of inputs, advance the model, check at negedge
    task automatic step(input bit fs, input bit ms, input bit esf);
        bit rf, rm, adv;
        fsync_in = fs;
        msync_in = ms;
        esf_mode = esf;
        @(posedge clk);
        rf = fs && !fprev;
        rm = ms && !mprev;
        fprev = fs;
        mprev = ms;
        if (rm) begin
            mb = 1;
            mf = 0;
        end else if (rf) begin
            adv = (mb != 0);
            mb = 1;
            if (adv) mf = (mf >= last_frame(esf)) ? 0 : mf + 1;
        end else if (mb == FBITS - 1) begin
            mb = 0;
            mf = (mf >= last_frame(esf)) ? 0 : mf + 1;
        end else begin
            mb = mb + 1;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic run_idle(input int n, input bit esf);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, esf);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f0;
        seed_dummy = $urandom(32'h5eed_71a1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 bit_pos", int'(bit_pos), 0);
        chk("R1 frame_idx", int'(frame_idx), 0);
        check_all();

        // R12 free run, one ESF multiframe returns to start
        run_idle(24 * FBITS, 1'b1);
        chk("R12 esf bit", int'(bit_pos), 0);
        chk("R12 esf frame", int'(frame_idx), 0);

        // R10 misaligned frame sync mid-frame
        run_idle(57, 1'b1);
        f0 = int'(frame_idx);
        step(1'b1, 1'b0, 1'b1);
        chk("R10 misaligned bit", int'(bit_pos), 1);
        chk("R10 misaligned frame", int'(frame_idx), f0 + 1);
        run_idle(3, 1'b1);
        // R10 aligned edge: wait until bit 0, then pulse
        while (bit_pos != 0) step(1'b0, 1'b0, 1'b1);
        f0 = int'(frame_idx);
        step(1'b1, 1'b0, 1'b1);
        chk("R10 aligned bit", int'(bit_pos), 1);
        chk("R10 aligned frame", int'(frame_idx), f0);
        // R10 level held high: no further realignment
        for (int i = 0; i < 3 * FBITS; i++) step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);

        // R11 multiframe sync mid-multiframe
        run_idle(1000, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R11 bit", int'(bit_pos), 1);
        chk("R11 frame", int'(frame_idx), 0);
        step(1'b0, 1'b0, 1'b1);
        run_idle(500, 1'b1);
        // R11 priority over simultaneous frame sync
        step(1'b1, 1'b1, 1'b1);
        chk("R11 priority bit", int'(bit_pos), 1);
        chk("R11 priority frame", int'(frame_idx), 0);
        step(1'b0, 1'b0, 1'b1);

        // R3 / R12 SF free run
        while (bit_pos != 0 || frame_idx != 0) step(1'b0, 1'b0, 1'b0);
        run_idle(12 * FBITS, 1'b0);
        chk("R12 sf bit", int'(bit_pos), 0);
        chk("R12 sf frame", int'(frame_idx), 0);

        // R3 switch to SF while past the SF limit
        while (frame_idx != 18) step(1'b0, 1'b0, 1'b1);
        run_idle(FBITS, 1'b0);
        chk("R3 over-limit wrap", int'(frame_idx), 0);

        // Constrained random: sparse sync pulses and format flips
        for (int i = 0; i < 60000; i++) begin
            bit fs, ms, esf;
            esf = esf_mode;
            if ($urandom_range(0, 4999) == 0) esf = ~esf;
            fs = ($urandom_range(0, 399) == 0) ? 1'b1 : 1'b0;
            if (fsync_in && $urandom_range(0, 3) != 0) fs = 1'b1;
            ms = ($urandom_range(0, 2999) == 0) ? 1'b1 : 1'b0;
            step(fs, ms, esf);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule